// File: doc/BRIEF.md
# Enclosure LED Status Serializer

This block drives the status LEDs of a drive enclosure over three wires: a serial clock, a load strobe and a data line. It holds one pattern register with three status bits for each drive port: activity, locate and fault. An LED message names a port. The block decodes the message into that port's three bits, writes them into the register and then sends the whole register out as a single frame.

Each port's bits go to the slot that a per-port mapping table gives. This lets the board wiring decide the order on the serial chain. A frame is a lead-in with the clock low, followed by a configurable number of idle pulses, one pulse with the load strobe high, three data bits per active port (least significant first) and a configurable number of trailing pulses. Every pulse holds the clock high for `HALF_CYC` cycles and then low for `HALF_CYC` cycles. While a frame is being sent the block deasserts ready, so messages wait and frames never overlap.

Top module: `encl_led_serializer`

## Requirements
- R1: A port's bits sit at pattern positions 3*s+k, where s is the slot that `slot_map_i` gives for that port (field p occupies bits 3p+2..3p). k=0 is activity, k=1 is locate and k=2 is fault. Frame data bit b is pattern bit b.
- R2: The message sets activity when bit 20 or bit 21 is 1, sets locate from bit 19 and sets fault from bit 22. Each of the three bits is written to 0 or 1 to match. The bits of other slots and all other message bits have no effect.
- R3: A message whose bits 15:8 are not below `MAX_SLOTS` is dropped. It changes no pattern bit, starts no frame and leaves all three pins unchanged.
- R4: A frame gives, in order: `pre_clks_i` clock pulses with load low, one pulse with load high, 3*n data pulses, and `post_clks_i` pulses with load low. The pulses are counted on rising clock edges.
- R5: Each clock pulse is high for exactly `HALF_CYC` cycles and then low for `HALF_CYC` cycles. The frame opens with `HALF_CYC` low cycles. Load and data change only while the clock is low.
- R6: n is `n_ports_i`, limited to `NUM_PORTS`. A value of 0 sends no data bits.
- R7: After reset the clock, load and data pins are all high, busy is low and ready is high.
- R8: Ready is low exactly while busy is high. Busy lasts HALF_CYC*(1+2*T) cycles after acceptance, where T is the number of pulses in the frame. A message presented while busy is not taken.
- R9: A frame sends the pattern and the pre, post and port counts as they stood when the message was accepted. Later input changes do not alter it.
- R10: Between frames the clock and load stay low and data keeps the last bit that was sent. With no data bits sent, data keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | LED message present |
| msg_ready_o | output | 1 | Block can take a message |
| msg_data_i | input | 32 | LED message word |
| msg_port_i | input | PORT_W | Port the message applies to |
| slot_map_i | input | NUM_PORTS*PORT_W | Slot for each port, field p for port p |
| n_ports_i | input | PORT_W+1 | Active port count |
| pre_clks_i | input | CNT_W | Idle pulses before load |
| post_clks_i | input | CNT_W | Trailing pulses after data |
| sclk_o | output | 1 | Serial clock |
| sload_o | output | 1 | Load strobe |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong bit in the pattern register shows up in the very next frame, as a wrong level on data at one known rising clock edge. A wrong slot or phase counter shows up within the same frame: the number of pulses is off, load lands on the wrong pulse, or the busy window has the wrong length. A message that is wrongly accepted or wrongly dropped leaves a stale or foreign bit. That bit shows up in the next frame, because every frame carries the full register.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  localparam int MSG_W     = 32;
  localparam int LED_BITS  = 3;
  localparam int ACT_A_BIT = 20;
  localparam int ACT_B_BIT = 21;
  localparam int LOC_BIT   = 19;
  localparam int FLT_BIT   = 22;
  localparam int SLOT_LSB  = 8;
  localparam int SLOT_W    = 8;

  // k=0 activity at LSB
  typedef struct packed {
    logic fault;
    logic locate;
    logic activity;
  } led_bits_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_HIGH,
    SEQ_LOW
  } seq_state_e;
endpackage

// File: rtl/led_msg_decode.sv
module led_msg_decode
  import led_ser_pkg::*;
#(
  parameter int MAX_SLOTS = 8
) (
  input  logic [MSG_W-1:0] msg_i,
  output led_bits_t        bits_o,
  output logic             slot_ok_o
);
  logic [SLOT_W-1:0] slot_idx;

  assign slot_idx  = msg_i[SLOT_LSB +: SLOT_W];
  assign slot_ok_o = (32'(slot_idx) < 32'(MAX_SLOTS));

  always_comb begin
    bits_o.activity = msg_i[ACT_A_BIT] | msg_i[ACT_B_BIT];
    bits_o.locate   = msg_i[LOC_BIT];
    bits_o.fault    = msg_i[FLT_BIT];
  end
endmodule

// File: rtl/led_pattern_reg.sv
module led_pattern_reg
  import led_ser_pkg::*;
#(
  parameter  int NUM_PORTS = 8,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PAT_W     = LED_BITS * NUM_PORTS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [PORT_W-1:0]           port_i,
  input  logic [NUM_PORTS*PORT_W-1:0] slot_map_i,
  input  led_bits_t                   bits_i,
  output logic [PAT_W-1:0]            pattern_o,
  output logic [PAT_W-1:0]            pattern_next_o
);
  logic [PAT_W-1:0]  pat_q;
  logic [PORT_W-1:0] tgt_slot;

  assign tgt_slot = slot_map_i[32'(port_i)*PORT_W +: PORT_W];

  for (genvar s = 0; s < NUM_PORTS; s++) begin : g_slot
    assign pattern_next_o[s*LED_BITS +: LED_BITS] =
      (we_i && tgt_slot == PORT_W'(s)) ? bits_i : pat_q[s*LED_BITS +: LED_BITS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pat_q <= '0;
    else         pat_q <= pattern_next_o;
  end

  assign pattern_o = pat_q;

  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pattern_o));
endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
  import led_ser_pkg::*;
#(
  parameter  int NUM_PORTS = 8,
  parameter  int HALF_CYC  = 6250,
  parameter  int CNT_W     = 8,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PAT_W     = LED_BITS * NUM_PORTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [PORT_W:0]  n_ports_i,
  input  logic [CNT_W-1:0] pre_i,
  input  logic [CNT_W-1:0] post_i,
  output logic             sclk_o,
  output logic             sload_o,
  output logic             sdata_o,
  output logic             busy_o
);
  localparam int HC_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W   = $clog2(PAT_W + 1);
  localparam int SLOT_CW = ((CNT_W > BIT_W) ? CNT_W : BIT_W) + 2;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  seq_state_e         state_q;
  logic [HC_W-1:0]    half_q;
  logic [SLOT_CW-1:0] slot_q, load_at_q, data_end_q, last_q;
  logic [PAT_W-1:0]   shreg_q;
  logic               sclk_q, sload_q, sdata_q;

  logic [SLOT_CW-1:0] n_eff, nbits, cap_load, cap_end, cap_last, nxt_slot;
  logic               half_done, nxt_is_data;

  always_comb begin
    n_eff = (SLOT_CW'(n_ports_i) > SLOT_CW'(NUM_PORTS)) ? SLOT_CW'(NUM_PORTS)
                                                         : SLOT_CW'(n_ports_i);
    nbits       = SLOT_CW'(LED_BITS) * n_eff;
    cap_load    = SLOT_CW'(pre_i);
    cap_end     = cap_load + SLOT_CW'(1) + nbits;
    cap_last    = cap_end + SLOT_CW'(post_i) - SLOT_CW'(1);
    nxt_slot    = slot_q + SLOT_CW'(1);
    half_done   = (half_q == HC_LAST);
    nxt_is_data = (nxt_slot > load_at_q) && (nxt_slot < data_end_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      half_q     <= '0;
      slot_q     <= '0;
      load_at_q  <= '0;
      data_end_q <= '0;
      last_q     <= '0;
      shreg_q    <= '0;
      sclk_q     <= 1'b1;
      sload_q    <= 1'b1;
      sdata_q    <= 1'b1;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q    <= SEQ_LEAD;
            half_q     <= '0;
            sclk_q     <= 1'b0;
            sload_q    <= (pre_i == '0);
            shreg_q    <= pattern_i;
            load_at_q  <= cap_load;
            data_end_q <= cap_end;
            last_q     <= cap_last;
          end
        end
        SEQ_LEAD: begin
          if (half_done) begin
            state_q <= SEQ_HIGH;
            half_q  <= '0;
            sclk_q  <= 1'b1;
            slot_q  <= '0;
          end else begin
            half_q <= half_q + HC_W'(1);
          end
        end
        SEQ_HIGH: begin
          if (half_done) begin
            state_q <= SEQ_LOW;
            half_q  <= '0;
            sclk_q  <= 1'b0;
            // next pulse's load/data are set up on this falling edge
            if (slot_q != last_q) begin
              sload_q <= (nxt_slot == load_at_q);
              if (nxt_is_data) begin
                sdata_q <= shreg_q[0];
                shreg_q <= shreg_q >> 1;
              end
            end else begin
              sload_q <= 1'b0;
            end
          end else begin
            half_q <= half_q + HC_W'(1);
          end
        end
        SEQ_LOW: begin
          if (half_done) begin
            half_q <= '0;
            if (slot_q == last_q) begin
              state_q <= SEQ_IDLE;
            end else begin
              state_q <= SEQ_HIGH;
              sclk_q  <= 1'b1;
              slot_q  <= nxt_slot;
            end
          end else begin
            half_q <= half_q + HC_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_q;
  assign sload_o = sload_q;
  assign sdata_o = sdata_q;
  assign busy_o  = (state_q != SEQ_IDLE);

  a_r8_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == SEQ_IDLE);

  a_r5_setup_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($stable(sload_o) && $stable(sdata_o)));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && !start_i) |=>
      ($stable(sclk_o) && $stable(sload_o) && $stable(sdata_o)));
endmodule

// File: rtl/encl_led_serializer.sv
module encl_led_serializer
  import led_ser_pkg::*;
#(
  parameter  int NUM_PORTS = 8,
  parameter  int MAX_SLOTS = 8,
  parameter  int HALF_CYC  = 6250,
  parameter  int CNT_W     = 8,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PAT_W     = LED_BITS * NUM_PORTS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        msg_valid_i,
  output logic                        msg_ready_o,
  input  logic [MSG_W-1:0]            msg_data_i,
  input  logic [PORT_W-1:0]           msg_port_i,
  input  logic [NUM_PORTS*PORT_W-1:0] slot_map_i,
  input  logic [PORT_W:0]             n_ports_i,
  input  logic [CNT_W-1:0]            pre_clks_i,
  input  logic [CNT_W-1:0]            post_clks_i,
  output logic                        sclk_o,
  output logic                        sload_o,
  output logic                        sdata_o,
  output logic                        busy_o
);
  logic             busy, slot_ok, accept, wr_en;
  led_bits_t        dec_bits;
  logic [PAT_W-1:0] pat_q, pat_next;

  assign accept      = msg_valid_i && !busy;
  assign wr_en       = accept && slot_ok;
  assign msg_ready_o = !busy;
  assign busy_o      = busy;

  led_msg_decode #(.MAX_SLOTS(MAX_SLOTS)) u_decode (
    .msg_i     (msg_data_i),
    .bits_o    (dec_bits),
    .slot_ok_o (slot_ok)
  );

  led_pattern_reg #(.NUM_PORTS(NUM_PORTS)) u_pattern (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .we_i           (wr_en),
    .port_i         (msg_port_i),
    .slot_map_i     (slot_map_i),
    .bits_i         (dec_bits),
    .pattern_o      (pat_q),
    .pattern_next_o (pat_next)
  );

  led_frame_seq #(
    .NUM_PORTS (NUM_PORTS),
    .HALF_CYC  (HALF_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (wr_en),
    .pattern_i (pat_next),
    .n_ports_i (n_ports_i),
    .pre_i     (pre_clks_i),
    .post_i    (post_clks_i),
    .sclk_o    (sclk_o),
    .sload_o   (sload_o),
    .sdata_o   (sdata_o),
    .busy_o    (busy)
  );

  a_r3_reject_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_ready_o && !slot_ok) |=> (!busy_o && $stable(pat_q)));

  a_r8_blocked_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && !msg_ready_o) |=> $stable(pat_q));
endmodule

// File: tb/encl_led_serializer_tb_top.sv
module encl_led_serializer_tb_top;
  localparam int NP = 8;
  localparam int HC = 2;
  localparam int CW = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          msg_valid = 1'b0;
  logic [31:0]   msg_data = '0;
  logic [PW-1:0] msg_port = '0;
  logic [NP*PW-1:0] slot_map_v = '0;
  logic [PW:0]   n_ports = '0;
  logic [CW-1:0] pre_c = '0, post_c = '0;
  logic msg_ready, sclk, sload, sdata, busy;

  encl_led_serializer #(.NUM_PORTS(NP), .MAX_SLOTS(8), .HALF_CYC(HC), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .msg_valid_i(msg_valid), .msg_ready_o(msg_ready),
    .msg_data_i(msg_data), .msg_port_i(msg_port), .slot_map_i(slot_map_v),
    .n_ports_i(n_ports), .pre_clks_i(pre_c), .post_clks_i(post_c),
    .sclk_o(sclk), .sload_o(sload), .sdata_o(sdata), .busy_o(busy));

  int n_checks = 0, n_fail = 0;
  logic [NP*3-1:0] exp_pat = '0;
  logic exp_sdata = 1'b1;

  // pin monitor
  int n_rise = 0, mon_err = 0, hi_cnt = 0;
  bit seen_rise = 0;
  logic prev_sclk = 1'b1, prev_load = 1'b1, prev_data = 1'b1;
  logic load_rec [256];
  logic data_rec [256];

  always @(negedge clk) begin
    if (rst_ni) begin
      if (sclk && !prev_sclk) begin
        load_rec[n_rise % 256] = sload;
        data_rec[n_rise % 256] = sdata;
        n_rise++;
        hi_cnt = 1;
        seen_rise = 1;
      end else if (sclk && prev_sclk) begin
        hi_cnt++;
      end
      if (!sclk && prev_sclk && seen_rise && hi_cnt != HC) mon_err++;
      if (sclk && (sload !== prev_load || sdata !== prev_data)) mon_err++;
    end
    prev_sclk = sclk;
    prev_load = sload;
    prev_data = sdata;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic set_map(input bit rev);
    for (int p = 0; p < NP; p++)
      slot_map_v[p*PW +: PW] = rev ? PW'(NP - 1 - p) : PW'((p * 3 + 5) % NP);
  endtask

  function automatic logic [31:0] mk_msg(input int port, input int c);
    logic [31:0] m;
    m = 32'(port * 17) & 32'hFF;
    m[15:8] = 8'(port);
    if (c[0]) begin
      if (port % 2 == 1) m[21] = 1'b1; else m[20] = 1'b1;
    end
    m[19] = c[1];
    m[22] = c[2];
    return m;
  endfunction

  task automatic run_frame(input int port, input logic [31:0] msg, input int pre,
                           input int post, input int n, input bit disturb);
    int base, err0, blen, t_len, ne, lm, s;
    logic [23:0] got, mask;
    logic [2:0] pins0;
    bit ok;
    ok = (msg[15:8] < 8);
    @(negedge clk);
    msg_port = PW'(port); msg_data = msg; pre_c = CW'(pre); post_c = CW'(post);
    n_ports = (PW+1)'(n); msg_valid = 1'b1;
    base = n_rise; err0 = mon_err; pins0 = {sclk, sload, sdata};
    @(negedge clk);
    msg_valid = 1'b0;
    if (!ok) begin
      blen = 0;
      for (int i = 0; i < 20; i++) begin
        if (busy) blen++;
        @(negedge clk);
      end
      check("R3 busy cycles after bad slot", 32'(blen), 32'd0);
      check("R3 pulses after bad slot", 32'(n_rise - base), 32'd0);
      check("R3 pins after bad slot", 32'({sclk, sload, sdata}), 32'(pins0));
      return;
    end
    s = int'(slot_map_v[port*PW +: PW]);
    exp_pat[s*3]     = msg[20] | msg[21];
    exp_pat[s*3 + 1] = msg[19];
    exp_pat[s*3 + 2] = msg[22];
    ne = (n > NP) ? NP : n;
    t_len = pre + 1 + 3 * ne + post;
    blen = 0;
    while (busy && blen < 2000) begin
      blen++;
      if (disturb && blen == 4) begin
        msg_valid = 1'b1; msg_port = PW'((port + 1) % NP); msg_data = 32'h0078_0100;
        pre_c = 8'd7; post_c = 8'd5; n_ports = 4'd1;
        check("R8 ready low while busy", 32'(msg_ready), 32'd0);
      end
      if (disturb && blen == 8) msg_valid = 1'b0;
      @(negedge clk);
    end
    check("R8 busy length", 32'(blen), 32'(HC + 2 * HC * t_len));
    check("R4 pulse count", 32'(n_rise - base), 32'(t_len));
    if (disturb) check("R9 captured config pulse count", 32'(n_rise - base), 32'(t_len));
    lm = 0;
    for (int i = 0; i < t_len; i++)
      if (load_rec[(base + i) % 256] !== (i == pre)) lm++;
    check("R4 load position", 32'(lm), 32'd0);
    got = '0; mask = '0;
    for (int b = 0; b < 3 * ne; b++) begin
      got[b] = data_rec[(base + pre + 1 + b) % 256];
      mask[b] = 1'b1;
    end
    check("R1 R2 frame data", 32'(got), 32'(exp_pat & mask));
    check("R5 pulse timing and setup", 32'(mon_err - err0), 32'd0);
    if (ne > 0) exp_sdata = exp_pat[3 * ne - 1];
    check("R10 pins after frame", 32'({sclk, sload, sdata}), 32'({1'b0, 1'b0, exp_sdata}));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 got=running exp=done");
    finish_run();
  end

  initial begin : main
    set_map(1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 pins at reset", 32'({sclk, sload, sdata}), 32'h7);
    check("R7 busy at reset", 32'(busy), 32'd0);
    check("R7 ready at reset", 32'(msg_ready), 32'd1);

    // sweep: every port, every LED combination, varied pre/post (R1 R2 R4 R5)
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < 8; c++)
        run_frame(p, mk_msg(p, c), c % 3, p % 3, NP, 1'b0);

    // both activity bits, then remapped slots (R1 R2)
    run_frame(2, 32'h0030_0200, 0, 0, NP, 1'b0);
    set_map(1'b1);
    for (int p = 0; p < NP; p++) run_frame(p, mk_msg(p, (p * 5 + 3) % 8), 1, 2, NP, 1'b0);

    // fewer ports, none, and clamp (R6)
    run_frame(0, mk_msg(0, 7), 2, 1, 3, 1'b0);
    run_frame(1, mk_msg(1, 5), 0, 0, 0, 1'b0);
    run_frame(3, mk_msg(3, 6), 3, 3, 12, 1'b0);
    run_frame(4, mk_msg(4, 0), 0, 3, 1, 1'b0);

    // blocked message and config changes mid-frame (R8 R9)
    run_frame(5, mk_msg(5, 3), 2, 2, NP, 1'b1);
    run_frame(5, mk_msg(5, 3), 0, 0, NP, 1'b0);

    // bad slot indices (R3), then confirm pattern untouched
    run_frame(6, 32'h0078_0800, 0, 0, NP, 1'b0);
    run_frame(7, 32'h0078_FF00, 0, 0, NP, 1'b0);
    run_frame(0, mk_msg(0, 2), 1, 1, NP, 1'b0);

    finish_run();
  end
endmodule